// File: doc/BRIEF.md
# Clocked Read Port for a Two-Phase Self-Timed FIFO

This block sits at the output end of a self-timed FIFO that signals with two-phase (transition) handshakes, and presents that FIFO to a consumer running on an ordinary clock. The last FIFO cell announces a new word by toggling its request level and holding the word steady on its data lines. The port returns a two-phase acknowledge level; toggling it tells the cell that the word has been taken and that the cell may be refilled.

Inside the read clock domain, the request level first passes through a chain of synchronizing flip-flops. The port then compares it with its own acknowledge level. When the two levels differ, the cell holds an unread word and the ready output is high. On a clock edge where the consumer has its enable high while ready is high, the port captures the word into an output register and flips the acknowledge. The two levels then match again, the cell is empty, and ready drops. The upstream stage refills the cell with another request toggle, and the same sequence repeats. Both request polarities carry data in the same way.

Top module: `tp_fifo_rd_port`

## Requirements
- R1: While rst_n is low at a clock edge, up_ack, rd_ready and rd_data are all cleared to 0 by that edge.
- R2: rd_ready is high exactly when the request level, delayed by SYNC_STAGES flip-flops in the read clock domain, differs from up_ack. A toggle of up_req made between edges first shows on rd_ready after the SYNC_STAGES-th rising edge that follows it.
- R3: rd_en has no effect on an edge where rd_ready is low: up_ack and rd_data keep their values.
- R4: On an edge where rd_ready and rd_en are both high, up_ack inverts, and rd_ready is low after that edge.
- R5: On a consuming edge, rd_data loads the value on up_data. On every other edge, rd_data holds its value.
- R6: At most one word is consumed per clock edge. With rd_en held high, every word the FIFO offers is consumed exactly once.
- R7: Words are delivered on rd_data in the order the FIFO offers them, over both request polarities and repeated fill/empty rounds, with rd_en held or toggled freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Two-phase request level from the last FIFO cell (asynchronous) |
| up_data | input | DATA_W | Word held by the last FIFO cell, stable while the cell is full |
| up_ack | output | 1 | Two-phase acknowledge level returned to the FIFO |
| rd_ready | output | 1 | A word is available to the consumer |
| rd_en | input | 1 | Consumer takes the word on this edge |
| rd_data | output | DATA_W | Last consumed word, registered |

## Verification
The bench builds the port with DATA_W = 8 and SYNC_STAGES = 2. With this chain length, every request toggle reaches rd_ready on the second edge after it, so the reference model can predict ready, acknowledge and data exactly on every cycle. The 8-bit words come from a sequence whose values vary in every bit. Back-to-back refills with zero upstream gap, together with randomized gaps and consumer enables, cover both acknowledge polarities many times and the case where enable is already high when ready rises.

// File: rtl/rdp_pkg.sv
// Package: shared constants and helpers for the two-phase FIFO read port.
// Assumes: nothing; pure declarations.
package rdp_pkg;

    // Fewest flip-flops allowed in the request synchronizer chain.
    localparam int unsigned MIN_SYNC_STAGES = 2;

    // Two-phase handshake: a cell is full when request and acknowledge differ.
    function automatic logic phase_full(input logic req_lvl, input logic ack_lvl);
        return req_lvl ^ ack_lvl;
    endfunction

endpackage

// File: rtl/rdp_sync_chain.sv
// Module: rdp_sync_chain
// Brings an asynchronous level into the clk domain through STAGES flip-flops.
// Assumes: the input is a level that changes at most once per handshake and
// stays put long enough to be sampled; reset clears every stage to 0.
module rdp_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    import rdp_pkg::*;

    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_rest
                // Purpose: each later stage lets metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    // Purpose: elaboration-time guard on the chain length.
    initial begin
        if (STAGES < MIN_SYNC_STAGES)
            $error("rdp_sync_chain: STAGES below minimum");
    end

    // The output only ever moves to a value the previous stage held one edge earlier.
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_out == $past(stage_q[STAGES-2]))); // R2

endmodule

// File: rtl/rdp_phase_compare.sv
// Module: rdp_phase_compare
// Turns the synchronized request level and the local acknowledge level into
// a "cell full" flag and a one-edge consume strobe.
// Assumes: both inputs are clk-domain registers; purely combinational.
module rdp_phase_compare (
    input  logic req_sync,
    input  logic ack_lvl,
    input  logic take_en,
    output logic cell_full,
    output logic take
);
    import rdp_pkg::*;

    // Purpose: full when the two-phase levels differ; consume when enabled too.
    always_comb begin
        cell_full = phase_full(req_sync, ack_lvl);
        take      = cell_full & take_en;
    end

endmodule

// File: rtl/rdp_ack_ctrl.sv
// Module: rdp_ack_ctrl
// Holds the two-phase acknowledge flip-flop and the output data register.
// On a consume strobe it flips the acknowledge and captures the word.
// Assumes: the upstream word is stable while the cell is full (bundled data).
module rdp_ack_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    output logic              ack_lvl,
    output logic [DATA_W-1:0] word_out
);

    // Purpose: flip the acknowledge once per consumed word.
    always_ff @(posedge clk) begin
        if (!rst_n)    ack_lvl <= 1'b0;
        else if (take) ack_lvl <= ~ack_lvl;
    end

    // Purpose: capture the word on the consuming edge and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_out <= '0;
        else if (take) word_out <= word_in;
    end

    AST_ACK_TOGGLES_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ack_lvl != $past(ack_lvl))); // R4

    AST_ACK_STILL_WITHOUT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(ack_lvl)); // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(word_out)); // R5

endmodule

// File: rtl/tp_fifo_rd_port.sv
// Module: tp_fifo_rd_port (top)
// Read-side adapter from the last cell of a two-phase self-timed FIFO to a
// synchronous consumer. The request is synchronized, compared with the local
// acknowledge to form rd_ready, and a consume (rd_ready & rd_en) flips the
// acknowledge and registers the word onto rd_data.
// Assumes: upstream toggles up_req only while up_req == up_ack (cell empty),
// and holds up_data stable while the cell is full.
module tp_fifo_rd_port #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_ack,
    output logic              rd_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic req_sync;
    logic ack_lvl;
    logic cell_full;
    logic take;

    rdp_sync_chain #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (up_req),
        .sync_out (req_sync)
    );

    rdp_phase_compare u_cmp (
        .req_sync  (req_sync),
        .ack_lvl   (ack_lvl),
        .take_en   (rd_en),
        .cell_full (cell_full),
        .take      (take)
    );

    rdp_ack_ctrl #(
        .DATA_W   (DATA_W)
    ) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .word_in  (up_data),
        .ack_lvl  (ack_lvl),
        .word_out (rd_data)
    );

    assign up_ack   = ack_lvl;
    assign rd_ready = cell_full;

    // After a consume, the cell reads as empty (upstream cannot refill yet).
    AST_READY_DROPS_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && rd_en) |=> !rd_ready); // R4

    // Reset state leaves nothing to read.
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (!up_ack && !rd_ready && (rd_data == '0))); // R1

endmodule

// File: tb/sim_tp_fifo_rd_port.sv
// Bench: behavioural model of the read port, compared every clock, plus an
// upstream model that refills the last FIFO cell through the two-phase handshake.
module sim_tp_fifo_rd_port;

    localparam int DW = 8;
    localparam int SS = 2;
    localparam int MAXW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          up_req;
    logic [DW-1:0] up_data;
    logic          up_ack;
    logic          rd_ready;
    logic          rd_en;
    logic [DW-1:0] rd_data;

    always #10 clk = ~clk;   // 50 MHz

    tp_fifo_rd_port #(.DATA_W(DW), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_data(up_data),
        .up_ack(up_ack), .rd_ready(rd_ready), .rd_en(rd_en), .rd_data(rd_data)
    );

    integer n_chk = 0;
    integer n_fail = 0;
    integer cyc = 0;
    bit     timed_out = 0;

    // reference model state
    bit          m_s [SS];
    bit          m_ack;
    logic [DW-1:0] m_data;
    integer      consumed = 0;
    logic [DW-1:0] cons [MAXW];

    // upstream model state
    integer sent = 0;
    integer target = 0;
    integer gap = 0;
    integer max_gap = 0;
    bit     rand_en = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [DW-1:0] word_of(input integer i);
        return DW'((i * 73 + 19) ^ (i << 5));
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge, drive inputs.
    task automatic step();
        bit tk;
        @(posedge clk);
        cyc++;
        if (cyc > 20000) timed_out = 1;
        if (!rst_n) begin
            for (int i = 0; i < SS; i++) m_s[i] = 0;
            m_ack = 0;
            m_data = '0;
        end else begin
            tk = (m_s[SS-1] != m_ack) && rd_en;
            if (tk) begin
                m_ack = ~m_ack;
                m_data = up_data;
                if (consumed < MAXW) cons[consumed] = up_data;
                consumed++;
            end
            for (int i = SS-1; i > 0; i--) m_s[i] = m_s[i-1];
            m_s[0] = up_req;
        end
        @(negedge clk);
        chk(rd_ready == (m_s[SS-1] != m_ack), "R2 rd_ready", 32'(rd_ready), 32'(m_s[SS-1] != m_ack));
        chk(up_ack == m_ack, "R3/R4 up_ack", 32'(up_ack), 32'(m_ack));
        chk(rd_data == m_data, "R5 rd_data", 32'(rd_data), 32'(m_data));
        // upstream refills the cell only while it sees it empty
        if (rst_n && sent < target && up_req == up_ack) begin
            if (gap == 0) begin
                up_data = word_of(sent);
                up_req  = ~up_req;
                sent++;
                lfsr = next_rand(lfsr);
                gap = (max_gap == 0) ? 0 : int'(lfsr[7:0]) % (max_gap + 1);
            end else begin
                gap--;
            end
        end
        if (rand_en) begin
            lfsr = next_rand(lfsr);
            rd_en = lfsr[3] | lfsr[9];
        end
    endtask

    initial begin
        rst_n = 0; up_req = 0; up_data = 8'hA5; rd_en = 1;
        for (int i = 0; i < 3; i++) step();
        // R1: reset values observed while reset is held, with rd_en high
        chk(up_ack == 0 && rd_ready == 0 && rd_data == 0, "R1 reset state",
            {up_ack, rd_ready, 8'h0, rd_data}, 32'h0);
        rst_n = 1;
        rd_en = 0;

        // R3: a word arrives but the consumer does not take it
        target = 1; max_gap = 0;
        for (int i = 0; i < 10; i++) step();
        chk(rd_ready == 1, "R3 word waiting", 32'(rd_ready), 32'd1);
        chk(up_ack == 0 && rd_data == 0, "R3 no effect without take",
            {up_ack, 8'h0, rd_data}, 32'h0);

        // R6: continuous enable, zero upstream gap, 16 words
        rd_en = 1; target = 16;
        while (!timed_out && (consumed < 16 || rd_ready)) step();
        for (int i = 0; i < 4; i++) step();
        chk(consumed == 16, "R6 one take per word", 32'(consumed), 32'd16);

        // R3: enable high with nothing offered must not consume
        for (int i = 0; i < 6; i++) step();
        chk(consumed == 16 && up_ack == 0, "R3 idle enable", {up_ack, 8'h0, 8'(consumed)}, 32'd16);

        // R7: random consumer enables and upstream gaps
        rand_en = 1; max_gap = 5; target = 40;
        while (!timed_out && consumed < 40) step();
        rand_en = 0; rd_en = 1;
        for (int i = 0; i < 6; i++) step();
        chk(consumed == 40, "R6 total consumed", 32'(consumed), 32'd40);
        for (int i = 0; i < 40; i++)
            chk(cons[i] == word_of(i), "R7 order", 32'(cons[i]), 32'(word_of(i)));

        if (timed_out) chk(0, "watchdog", 32'(cyc), 32'd20000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule